// File: doc/BRIEF.md
# Debug Port Control and Status Register

This block holds the control and status word of a debug port. Two configuration fields, a byte-lane mask and a transfer mode, are ordinary read/write storage. Four status flags record what happened to transactions sent on to an access port. The flags are a write-data error, the outcome of the most recent read, an access-port error and a compare match. The transaction engine drives one-cycle event strobes into the block. The host reads the whole word combinationally and writes it through a single write strobe.

The clear path for the access-port error and compare flags depends on the port flavour, which is a parameter. On the scan-chain flavour, writing one to the flag's own bit clears it. On the serial-wire flavour, only strobes from the separate abort register clear these flags, and register writes to the status bits do nothing. On both flavours, the write-data error flag is cleared only by its abort strobe, and the read-status flag only follows read responses. When a set event and a clear request arrive in the same cycle, the flag stays set.

Top module: `dp_ctrlstat`

## Requirements
- R1: After the asynchronous active-low reset, bits 7, 6, 5 and 4 read 0. The configuration fields are not defined until their first write.
- R2: A register write stores wdata[11:8] as the byte-lane mask and wdata[3:2] as the transfer mode. Both read back in place from the next cycle, and they hold when no write occurs.
- R3: Bits [31:12] and [1:0] always read 0, and writes to those bits are ignored.
- R4: Bit 7 (write-data error) is set in the cycle after a data-phase parity/framing error strobe or a dropped-write strobe. It then stays set.
- R5: Bit 7 is cleared only by the abort write-data-error clear strobe. A register write has no effect on it in either flavour.
- R6: On each read-done strobe, bit 6 takes the value of the read-ok input. Between strobes it holds, and register writes do not change it.
- R7: Bit 5 is set by the access-port error strobe, and bit 4 is set by the compare-match strobe. Both are sticky.
- R8: On the scan-chain flavour, a register write with a one in bit 5 or bit 4 clears that flag. A zero written there leaves the flag unchanged, and the abort clear strobes for these two flags have no effect.
- R9: On the serial-wire flavour, the abort clear strobes clear bit 5 and bit 4. Register writes to bits 7 to 4 have no effect.
- R10: When a set event and a clear request for a flag occur in the same cycle, the flag is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data |
| wr_data_err_i | input | 1 | Parity or framing error in a write data phase |
| wr_drop_i | input | 1 | Accepted write discarded before reaching the access port |
| rd_done_i | input | 1 | Response to an access-port or read-buffer read has arrived |
| rd_ok_i | input | 1 | That response was OK (qualified by rd_done_i) |
| ap_err_i | input | 1 | Access-port transaction returned an error |
| cmp_match_i | input | 1 | Pushed compare or verify matched |
| abt_wderr_clr_i | input | 1 | Abort register: clear the write-data error flag |
| abt_stkerr_clr_i | input | 1 | Abort register: clear the sticky error flag |
| abt_stkcmp_clr_i | input | 1 | Abort register: clear the sticky compare flag |

## Verification
The bench builds two copies of the block side by side, one with FLAVOR set to the scan-chain value and one with the serial-wire value, and drives both with the same stimulus. Each vector carries a separate expected word for each flavour, so every divergence between the flavours is checked in the same cycle. The divergences are whether a written one clears a flag and whether the abort strobes reach bits 5 and 4. DATA_W stays at 32, so the bench also covers the always-zero upper bits.

// File: rtl/dp_ctrlstat_pkg.sv
package dp_ctrlstat_pkg;
  localparam int unsigned MASK_LSB   = 8;
  localparam int unsigned MASK_W     = 4;
  localparam int unsigned WDERR_BIT  = 7;
  localparam int unsigned RDOK_BIT   = 6;
  localparam int unsigned STKERR_BIT = 5;
  localparam int unsigned STKCMP_BIT = 4;
  localparam int unsigned TRN_LSB    = 2;
  localparam int unsigned TRN_W      = 2;
  localparam int unsigned USED_W     = MASK_LSB + MASK_W;

  typedef enum logic {
    FLAV_JTAG  = 1'b0,
    FLAV_SWIRE = 1'b1
  } dp_flavor_e;
endpackage

// File: rtl/dp_sticky_bit.sv
module dp_sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= 1'b0;
    else if (set_i) q_q <= 1'b1;  // set has priority over clear
    else if (clr_i) q_q <= 1'b0;
  end

  assign q_o = q_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o) else $error("set lost");  // R10
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o) else $error("clear lost");  // R8
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o)) else $error("flag moved");  // R7
endmodule

// File: rtl/dp_cfg_field.sv
module dp_cfg_field #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  // Architecturally undefined after reset; cleared here for deterministic simulation.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (we_i) q_q <= d_i;
  end

  assign q_o = q_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o)) else $error("cfg moved");  // R2
  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(d_i))) else $error("cfg not loaded");  // R2
endmodule

// File: rtl/dp_ctrlstat.sv
module dp_ctrlstat
  import dp_ctrlstat_pkg::*;
#(
  parameter dp_flavor_e  FLAVOR = FLAV_JTAG,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              wr_data_err_i,
  input  logic              wr_drop_i,
  input  logic              rd_done_i,
  input  logic              rd_ok_i,
  input  logic              ap_err_i,
  input  logic              cmp_match_i,
  input  logic              abt_wderr_clr_i,
  input  logic              abt_stkerr_clr_i,
  input  logic              abt_stkcmp_clr_i
);
  logic [MASK_W-1:0] mask_q;
  logic [TRN_W-1:0]  trn_q;
  logic              wderr_q, rdok_q, stkerr_q, stkcmp_q;
  logic              stkerr_clr, stkcmp_clr;
  logic              unused_in;

  dp_cfg_field #(.W(MASK_W)) u_mask (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (reg_we_i),
    .d_i   (reg_wdata_i[MASK_LSB +: MASK_W]), .q_o (mask_q)
  );

  dp_cfg_field #(.W(TRN_W)) u_trn (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (reg_we_i),
    .d_i   (reg_wdata_i[TRN_LSB +: TRN_W]), .q_o (trn_q)
  );

  dp_sticky_bit u_wderr (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (wr_data_err_i | wr_drop_i), .clr_i (abt_wderr_clr_i), .q_o (wderr_q)
  );

  // Clear path for the two sticky flags depends on port flavour
  generate
    if (FLAVOR == FLAV_JTAG) begin : g_w1c
      assign stkerr_clr = reg_we_i & reg_wdata_i[STKERR_BIT];
      assign stkcmp_clr = reg_we_i & reg_wdata_i[STKCMP_BIT];
      assign unused_in  = ^{abt_stkerr_clr_i, abt_stkcmp_clr_i, reg_wdata_i[WDERR_BIT],
                            reg_wdata_i[RDOK_BIT], reg_wdata_i[TRN_LSB-1:0],
                            reg_wdata_i[DATA_W-1:USED_W]};

      AST_JTAG_ABT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (abt_stkerr_clr_i && !ap_err_i && !(reg_we_i && reg_wdata_i[STKERR_BIT]))
          |=> $stable(reg_rdata_o[STKERR_BIT])) else $error("abort cleared w1c flag");  // R8
    end else begin : g_abort
      assign stkerr_clr = abt_stkerr_clr_i;
      assign stkcmp_clr = abt_stkcmp_clr_i;
      assign unused_in  = ^{reg_wdata_i[WDERR_BIT:STKCMP_BIT], reg_wdata_i[TRN_LSB-1:0],
                            reg_wdata_i[DATA_W-1:USED_W]};

      AST_SW_REG_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && !ap_err_i && !abt_stkerr_clr_i && !cmp_match_i && !abt_stkcmp_clr_i)
          |=> ($stable(reg_rdata_o[STKERR_BIT]) && $stable(reg_rdata_o[STKCMP_BIT])))
        else $error("write touched flag");  // R9
    end
  endgenerate

  dp_sticky_bit u_stkerr (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (ap_err_i), .clr_i (stkerr_clr), .q_o (stkerr_q)
  );

  dp_sticky_bit u_stkcmp (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (cmp_match_i), .clr_i (stkcmp_clr), .q_o (stkcmp_q)
  );

  // Read-status flag tracks the last read response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdok_q <= 1'b0;
    else if (rd_done_i) rdok_q <= rd_ok_i;
  end

  always_comb begin
    reg_rdata_o                       = '0;
    reg_rdata_o[MASK_LSB +: MASK_W]   = mask_q;
    reg_rdata_o[WDERR_BIT]            = wderr_q;
    reg_rdata_o[RDOK_BIT]             = rdok_q;
    reg_rdata_o[STKERR_BIT]           = stkerr_q;
    reg_rdata_o[STKCMP_BIT]           = stkcmp_q;
    reg_rdata_o[TRN_LSB +: TRN_W]     = trn_q;
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[DATA_W-1:USED_W] == '0) && (reg_rdata_o[TRN_LSB-1:0] == '0))
    else $error("unused bits nonzero");  // R3
  AST_WDERR_REG_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !wr_data_err_i && !wr_drop_i && !abt_wderr_clr_i)
      |=> $stable(reg_rdata_o[WDERR_BIT])) else $error("write touched wderr");  // R5
  AST_RDOK_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_i |=> (reg_rdata_o[RDOK_BIT] == $past(rd_ok_i))) else $error("rdok wrong");  // R6
  AST_RDOK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_done_i |=> $stable(reg_rdata_o[RDOK_BIT])) else $error("rdok moved");  // R6
  AST_WDERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data_err_i || wr_drop_i) |=> reg_rdata_o[WDERR_BIT]) else $error("wderr not set");  // R4
endmodule

// File: tb/sim_dp_ctrlstat.sv
module sim_dp_ctrlstat;
  import dp_ctrlstat_pkg::*;

  localparam int DW = 32;
  localparam int NV = 16;
  // {req[3:0], we, wdata[11:0], ev{wde,drop,rdd,rdok,aperr,cmp}, abt{wd,se,sc}, exp_jtag[11:0], exp_swire[11:0]}
  localparam int VW = 4 + 1 + 12 + 6 + 3 + 12 + 12;
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd2,  1'b1, 12'hFFF, 6'b000000, 3'b000, 12'hF0C, 12'hF0C},  // R2 R3 full write
    {4'd2,  1'b1, 12'h5A4, 6'b000000, 3'b000, 12'h504, 12'h504},  // R2 R5 flag bits ignored
    {4'd4,  1'b0, 12'h000, 6'b100000, 3'b000, 12'h584, 12'h584},  // R4 data error
    {4'd7,  1'b0, 12'h000, 6'b000011, 3'b011, 12'h5B4, 12'h5B4},  // R7 R10 set vs abort
    {4'd8,  1'b1, 12'h030, 6'b000000, 3'b000, 12'h080, 12'h0B0},  // R8 R9 w1c vs ignored
    {4'd9,  1'b0, 12'h000, 6'b000000, 3'b011, 12'h080, 12'h080},  // R8 R9 abort clear
    {4'd6,  1'b0, 12'h000, 6'b001100, 3'b000, 12'h0C0, 12'h0C0},  // R6 read ok
    {4'd6,  1'b0, 12'h000, 6'b000000, 3'b000, 12'h0C0, 12'h0C0},  // R6 hold
    {4'd6,  1'b0, 12'h000, 6'b001000, 3'b000, 12'h080, 12'h080},  // R6 read not ok
    {4'd5,  1'b0, 12'h000, 6'b000000, 3'b100, 12'h000, 12'h000},  // R5 abort clear
    {4'd4,  1'b0, 12'h000, 6'b010000, 3'b000, 12'h080, 12'h080},  // R4 dropped write
    {4'd10, 1'b0, 12'h000, 6'b010000, 3'b100, 12'h080, 12'h080},  // R10 set beats abort
    {4'd5,  1'b1, 12'h0C8, 6'b000000, 3'b000, 12'h088, 12'h088},  // R5 R6 write ignored
    {4'd10, 1'b1, 12'h020, 6'b000010, 3'b000, 12'h0A0, 12'h0A0},  // R10 set beats w1c
    {4'd10, 1'b0, 12'h000, 6'b000010, 3'b010, 12'h0A0, 12'h0A0},  // R10 set beats abort
    {4'd8,  1'b1, 12'h000, 6'b000000, 3'b100, 12'h020, 12'h020}   // R8 zero write keeps
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic wde = 0, drop = 0, rdd = 0, rdok = 0, aperr = 0, cmp = 0;
  logic awd = 0, ase = 0, asc = 0;
  logic [DW-1:0] rd_j, rd_s;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dp_ctrlstat #(.FLAVOR(FLAV_JTAG), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rd_j),
    .wr_data_err_i(wde), .wr_drop_i(drop), .rd_done_i(rdd), .rd_ok_i(rdok),
    .ap_err_i(aperr), .cmp_match_i(cmp), .abt_wderr_clr_i(awd),
    .abt_stkerr_clr_i(ase), .abt_stkcmp_clr_i(asc));

  dp_ctrlstat #(.FLAVOR(FLAV_SWIRE), .DATA_W(DW)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rd_s),
    .wr_data_err_i(wde), .wr_drop_i(drop), .rd_done_i(rdd), .rd_ok_i(rdok),
    .ap_err_i(aperr), .cmp_match_i(cmp), .abt_wderr_clr_i(awd),
    .abt_stkerr_clr_i(ase), .abt_stkcmp_clr_i(asc));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    we = 0; wdata = '0; {wde, drop, rdd, rdok, aperr, cmp} = '0; {awd, ase, asc} = '0;
  endtask

  initial begin
    #(8 * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1: flags clear during and after reset
    chk("R1 jtag", {24'h0, rd_j[7:4]}, '0);
    chk("R1 swire", {24'h0, rd_s[7:4]}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      we = v[45]; wdata = {20'h0, v[44:33]};
      {wde, drop, rdd, rdok, aperr, cmp} = v[32:27];
      {awd, ase, asc} = v[26:24];
      @(posedge clk); #1;
      idle();
      chk($sformatf("R%0d vec%0d jtag", v[49:46], i), rd_j, {20'h0, v[23:12]});
      chk($sformatf("R%0d vec%0d swire", v[49:46], i), rd_s, {20'h0, v[11:0]});
      @(negedge clk);
    end

    // R3: upper bits written with ones stay zero
    we = 1; wdata = 32'hFFFF_F003;
    @(posedge clk); #1; idle();
    chk("R3 upper jtag", {rd_j[31:12], 10'h0, rd_j[1:0]}, '0);
    chk("R3 upper swire", {rd_s[31:12], 10'h0, rd_s[1:0]}, '0);
    @(negedge clk);

    // R7: compare flag sticky, then clear per flavour
    cmp = 1; @(posedge clk); #1; idle();
    repeat (2) @(negedge clk);
    chk("R7 cmp jtag", {31'h0, rd_j[4]}, 32'h1);
    chk("R7 cmp swire", {31'h0, rd_s[4]}, 32'h1);
    we = 1; wdata = 32'h10; @(posedge clk); #1; idle();
    chk("R8 cmp w1c jtag", {31'h0, rd_j[4]}, 32'h0);
    chk("R9 cmp write ignored swire", {31'h0, rd_s[4]}, 32'h1);
    @(negedge clk);
    asc = 1; @(posedge clk); #1; idle();
    chk("R9 cmp abort swire", {31'h0, rd_s[4]}, 32'h0);
    @(negedge clk);

    // R1: mid-run reset clears set flags
    wde = 1; aperr = 1; @(posedge clk); #1; idle();
    @(negedge clk); rst_n = 0; #2;
    chk("R1 rerst jtag", {24'h0, rd_j[7:4]}, '0);
    chk("R1 rerst swire", {24'h0, rd_s[7:4]}, '0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule